// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block sits between a processor load/store port and a main memory that moves whole 512-bit lines. Each byte address maps to exactly one slot. Loads and stores that hit are served from the slot and cause no memory traffic. A miss is handled by a small sequencer. If the slot holds a modified line, that line is written back first. The new line is then read, installed, and used to finish the waiting request.

Stores that miss still allocate. The line is fetched and the store is merged into it, and the slot is marked dirty. Memory is written only when a dirty line is displaced. The memory answers reads only, so the fill read can follow a writeback on the very next cycle. Only one miss is handled at a time, and the processor port stalls until it is done.

Top module: `dcache_wb`

## Requirements
- R1: After reset every slot is invalid, `cpu_req_ready` is high, and `mem_req_valid` and `cpu_resp_valid` are low.
- R2: The byte address is split as follows. Bits [5:2] pick the 32-bit word, bits [9:6] pick one of 16 slots, and bits [29:10] form the tag. The memory line address is byte address bits [29:6]. Word k of a line sits at line bits [32k+31:32k].
- R3: A load hit raises `cpu_resp_valid` with the selected word on the cycle after the request is accepted, with no memory request.
- R4: A store hit replaces only the addressed word, marks the line dirty and issues no memory request. Stores give no response.
- R5: A load miss to a slot that is invalid or clean issues exactly one line read and installs the line. The response then carries the requested word from that line.
- R6: A store miss reads the line, merges the store word into it and installs it dirty. The other words keep their memory values.
- R7: A miss that replaces a dirty line first writes the whole victim line to the victim's line address. The fill read is issued on the cycle after that write is accepted.
- R8: Memory is never written by a store or by the replacement of a clean line.
- R9: While a miss is in progress, `cpu_req_ready` stays low. At most one miss is outstanding.
- R10: A memory request that is not accepted is held with the same address and direction until `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 30 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | Load data valid (one cycle) |
| cpu_resp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | 24 | Line address |
| mem_req_wdata | output | 512 | Line written back |
| mem_resp_valid | input | 1 | Read line returned |
| mem_resp_data | input | 512 | Returned line |

## Verification
The bench uses the default build: 16 slots, 512-bit lines and 32-bit words. With this size, every slot and every word position can be swept. It first fills all slots, then reads back all 256 words as hits, then stores into each slot. Next it evicts every slot with a second tag, and finally brings lines back from memory. The memory model accepts requests on a toggling ready and answers reads after a fixed delay. This puts the held-request and writeback-then-fill orderings under back-pressure, and it lets the bench count line reads and writes exactly against the totals the requirements predict.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,  // serving hits, accepting requests
    MS_VICTIM = 2'd1,  // write back dirty victim if any
    MS_FETCH  = 2'd2,  // issue line read
    MS_FILL   = 2'd3   // wait for line, install, finish request
  } miss_state_e;

endpackage

// File: rtl/dcache_arrays.sv
module dcache_arrays #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  input  logic [LINE_W-1:0] wr_line
);

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  // State bits: reset clears valid, dirty follows each write.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // Tag and data storage: single write port, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int LINE_W     = 512,
  parameter int WORD_W     = 32,
  parameter int SETS       = 16,
  parameter int MEM_ADDR_W = 24,
  localparam int OFF_W     = $clog2(LINE_W / 8),
  localparam int ADDR_W    = MEM_ADDR_W + OFF_W,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int WORDS     = LINE_W / WORD_W,
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int BOFF_W    = $clog2(WORD_W / 8)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req_valid,
  output logic                  cpu_req_ready,
  input  logic                  cpu_req_write,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic [WORD_W-1:0]     cpu_req_wdata,
  output logic                  cpu_resp_valid,
  output logic [WORD_W-1:0]     cpu_resp_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [MEM_ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]     mem_req_wdata,
  input  logic                  mem_resp_valid,
  input  logic [LINE_W-1:0]     mem_resp_data,
  output logic [IDX_W-1:0]      arr_rd_idx,
  input  logic                  arr_valid,
  input  logic                  arr_dirty,
  input  logic [TAG_W-1:0]      arr_tag,
  input  logic [LINE_W-1:0]     arr_line,
  output logic                  arr_we,
  output logic [IDX_W-1:0]      arr_wr_idx,
  output logic [TAG_W-1:0]      arr_wr_tag,
  output logic                  arr_wr_dirty,
  output logic [LINE_W-1:0]     arr_wr_line
);

  miss_state_e         state_q;
  logic                pend_write_q;
  logic [ADDR_W-1:0]   pend_addr_q;
  logic [WORD_W-1:0]   pend_wdata_q;
  logic                resp_valid_q;
  logic [WORD_W-1:0]   resp_data_q;

  logic                idle;
  logic [ADDR_W-1:0]   cur_addr;
  logic                cur_write;
  logic [WORD_W-1:0]   cur_wdata;
  logic [IDX_W-1:0]    cur_idx;
  logic [TAG_W-1:0]    cur_tag;
  logic [WSEL_W-1:0]   cur_wsel;
  logic                hit;
  logic                accept;
  logic                victim_dirty;
  logic                fill_done;
  logic [LINE_W-1:0]   line_src;
  logic [LINE_W-1:0]   line_merged;
  logic [WORD_W-1:0]   word_sel;

  assign idle      = (state_q == MS_IDLE);
  assign cur_addr  = idle ? cpu_req_addr  : pend_addr_q;
  assign cur_write = idle ? cpu_req_write : pend_write_q;
  assign cur_wdata = idle ? cpu_req_wdata : pend_wdata_q;
  assign cur_idx   = cur_addr[OFF_W +: IDX_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_wsel  = cur_addr[BOFF_W +: WSEL_W];

  assign arr_rd_idx   = cur_idx;
  assign hit          = arr_valid && (arr_tag == cur_tag);
  assign accept       = idle && cpu_req_valid;
  assign victim_dirty = arr_valid && arr_dirty;
  assign fill_done    = (state_q == MS_FILL) && mem_resp_valid;

  // Word select and store merge over either the stored or the returned line.
  assign line_src = (state_q == MS_FILL) ? mem_resp_data : arr_line;

  always_comb begin
    line_merged = line_src;
    word_sel    = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (cur_wsel == WSEL_W'(k)) begin
        word_sel = line_src[k*WORD_W +: WORD_W];
        if (cur_write) line_merged[k*WORD_W +: WORD_W] = cur_wdata;
      end
    end
  end

  // Array write: store hit or line install.
  assign arr_we       = (accept && hit && cpu_req_write) || fill_done;
  assign arr_wr_idx   = cur_idx;
  assign arr_wr_tag   = cur_tag;
  assign arr_wr_dirty = (state_q == MS_FILL) ? pend_write_q : 1'b1;
  assign arr_wr_line  = line_merged;

  // Memory request port.
  assign mem_req_valid = ((state_q == MS_VICTIM) && victim_dirty) || (state_q == MS_FETCH);
  assign mem_req_write = (state_q == MS_VICTIM);
  assign mem_req_addr  = (state_q == MS_VICTIM) ? {arr_tag, cur_idx} : {cur_tag, cur_idx};
  assign mem_req_wdata = arr_line;

  assign cpu_req_ready  = idle;
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_data  = resp_data_q;

  // Miss sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_IDLE;
    end else begin
      case (state_q)
        MS_IDLE:   if (accept && !hit) state_q <= MS_VICTIM;
        MS_VICTIM: if (!victim_dirty || mem_req_ready) state_q <= MS_FETCH;
        MS_FETCH:  if (mem_req_ready) state_q <= MS_FILL;
        MS_FILL:   if (mem_resp_valid) state_q <= MS_IDLE;
        default:   state_q <= MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !hit) begin
      pend_write_q <= cpu_req_write;
      pend_addr_q  <= cpu_req_addr;
      pend_wdata_q <= cpu_req_wdata;
    end
  end

  // Registered load response.
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= (accept && hit && !cpu_req_write) || (fill_done && !pend_write_q);
      resp_data_q  <= word_sel;
    end
  end

  AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !cpu_req_ready);  // R9

  AST_HOLD_MEM_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));  // R10

  AST_FILL_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (mem_req_valid && !mem_req_write &&
       mem_req_addr[IDX_W-1:0] == $past(mem_req_addr[IDX_W-1:0])));  // R7

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && hit) |=> !mem_req_valid);  // R3

  AST_STORE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && cpu_req_write) |=> !cpu_resp_valid);  // R4

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int LINE_W     = 512,
  parameter int WORD_W     = 32,
  parameter int SETS       = 16,
  parameter int MEM_ADDR_W = 24,
  localparam int OFF_W     = $clog2(LINE_W / 8),
  localparam int ADDR_W    = MEM_ADDR_W + OFF_W,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req_valid,
  output logic                  cpu_req_ready,
  input  logic                  cpu_req_write,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic [WORD_W-1:0]     cpu_req_wdata,
  output logic                  cpu_resp_valid,
  output logic [WORD_W-1:0]     cpu_resp_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [MEM_ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]     mem_req_wdata,
  input  logic                  mem_resp_valid,
  input  logic [LINE_W-1:0]     mem_resp_data
);

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic              rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic              wr_dirty;
  logic [LINE_W-1:0] wr_line;

  dcache_arrays #(
    .SETS   (SETS),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
  ) u_arrays (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_dirty (wr_dirty),
    .wr_line  (wr_line)
  );

  dcache_ctrl #(
    .LINE_W     (LINE_W),
    .WORD_W     (WORD_W),
    .SETS       (SETS),
    .MEM_ADDR_W (MEM_ADDR_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_req_wdata  (cpu_req_wdata),
    .cpu_resp_valid (cpu_resp_valid),
    .cpu_resp_data  (cpu_resp_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .arr_rd_idx     (rd_idx),
    .arr_valid      (rd_valid),
    .arr_dirty      (rd_dirty),
    .arr_tag        (rd_tag),
    .arr_line       (rd_line),
    .arr_we         (wr_en),
    .arr_wr_idx     (wr_idx),
    .arr_wr_tag     (wr_tag),
    .arr_wr_dirty   (wr_dirty),
    .arr_wr_line    (wr_line)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (cpu_req_ready && !mem_req_valid && !cpu_resp_valid));  // R1

endmodule

// File: tb/tb_dcache_wb.sv
`timescale 1ns/1ps
module tb_dcache_wb;

  logic         clk = 1'b0;
  logic         rst;
  logic         cpu_req_valid;
  logic         cpu_req_ready;
  logic         cpu_req_write;
  logic [29:0]  cpu_req_addr;
  logic [31:0]  cpu_req_wdata;
  logic         cpu_resp_valid;
  logic [31:0]  cpu_resp_data;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic         mem_req_write;
  logic [23:0]  mem_req_addr;
  logic [511:0] mem_req_wdata;
  logic         mem_resp_valid;
  logic [511:0] mem_resp_data;

  always #4 clk = ~clk;

  dcache_wb dut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_data(cpu_resp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_rd  = 0;
  int n_wr  = 0;
  int stall_viol = 0;
  int hold_viol  = 0;
  int lat;
  logic [31:0] got;
  bit done = 0;

  function automatic logic [31:0] init_word(int line, int w);
    return {8'hA5, 16'(line), 8'(w)};
  endfunction
  function automatic logic [31:0] st_word(int s, int w);
    return {8'hD7, 8'(s), 8'h3C, 8'(w)};
  endfunction
  function automatic logic [29:0] mk(int tag, int idx, int w);
    return {20'(tag), 4'(idx), 4'(w), 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: line array, toggling ready, read data after 3 cycles.
  logic [511:0] bmem [256];
  int rdy_cnt;
  int resp_cnt;
  logic [7:0] rd_line;
  initial begin
    for (int l = 0; l < 256; l++)
      for (int w = 0; w < 16; w++)
        bmem[l][w*32 +: 32] = init_word(l, w);
  end

  always @(posedge clk) begin
    if (rst) begin
      rdy_cnt        <= 0;
      resp_cnt       <= 0;
      mem_req_ready  <= 1'b0;
      mem_resp_valid <= 1'b0;
      mem_resp_data  <= '0;
    end else begin
      rdy_cnt        <= rdy_cnt + 1;
      mem_req_ready  <= (rdy_cnt % 3) != 2;
      mem_resp_valid <= 1'b0;
      if (resp_cnt != 0) begin
        resp_cnt <= resp_cnt - 1;
        if (resp_cnt == 1) begin
          mem_resp_valid <= 1'b1;
          mem_resp_data  <= bmem[rd_line];
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          bmem[mem_req_addr[7:0]] <= mem_req_wdata;
          n_wr <= n_wr + 1;
        end else begin
          rd_line  <= mem_req_addr[7:0];
          resp_cnt <= 3;
          n_rd     <= n_rd + 1;
        end
      end
    end
  end

  // R10 monitor: an unaccepted request must reappear unchanged.
  logic        prev_wait = 1'b0;
  logic [23:0] prev_addr;
  logic        prev_wr;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_wait && !(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr))
        hold_viol++;
      prev_wait <= mem_req_valid && !mem_req_ready;
      prev_addr <= mem_req_addr;
      prev_wr   <= mem_req_write;
    end
  end

  task automatic issue(bit wr, logic [29:0] a, logic [31:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic do_load(logic [29:0] a, output logic [31:0] d);
    issue(1'b0, a, '0);
    lat = 1;
    while (!cpu_resp_valid) begin
      if (cpu_req_ready) stall_viol++;
      @(negedge clk);
      lat++;
    end
    d = cpu_resp_data;
  endtask

  task automatic do_store(logic [29:0] a, logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rd0;
    int wr0;
    rst = 1'b1;
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
    cpu_req_addr  = '0;
    cpu_req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", 32'(cpu_req_ready), 32'd1);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R1 resp_valid", 32'(cpu_resp_valid), 32'd0);

    // R5/R2: cold misses in every slot, word index equal to slot.
    for (int s = 0; s < 16; s++) begin
      do_load(mk(0, s, s), got);
      chk("R5 R2 cold miss word", got, init_word(s, s));
    end
    chk("R5 one read per miss", 32'(n_rd), 32'd16);
    chk("R8 no writes on clean fill", 32'(n_wr), 32'd0);

    // R3: every word of every slot hits with one-cycle response.
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++) begin
        do_load(mk(0, s, w), got);
        chk("R3 hit data", got, init_word(s, w));
        chk("R3 hit latency", 32'(lat), 32'd1);
      end
    chk("R3 no reads on hits", 32'(n_rd), 32'd16);

    // R4: one store per slot, then all words read back.
    for (int s = 0; s < 16; s++) do_store(mk(0, s, s), st_word(s, s));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++) begin
        do_load(mk(0, s, w), got);
        chk("R4 store hit merge", got, (w == s) ? st_word(s, s) : init_word(s, w));
      end
    chk("R4 no reads", 32'(n_rd), 32'd16);
    chk("R8 no writes on store hit", 32'(n_wr), 32'd0);

    // R7: evict every dirty slot with tag 1.
    for (int s = 0; s < 16; s++) begin
      do_load(mk(1, s, 0), got);
      chk("R7 fill after writeback", got, init_word(16 + s, 0));
    end
    chk("R7 writeback count", 32'(n_wr), 32'd16);
    chk("R7 read count", 32'(n_rd), 32'd32);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++)
        chk("R7 written-back word", bmem[s][w*32 +: 32],
            (w == s) ? st_word(s, s) : init_word(s, w));

    // R8: clean victims (tag 1) replaced by tag 0 again.
    for (int s = 0; s < 4; s++) begin
      do_load(mk(0, s, s), got);
      chk("R7 round trip", got, st_word(s, s));
    end
    chk("R8 clean eviction no write", 32'(n_wr), 32'd16);
    chk("R5 reads", 32'(n_rd), 32'd36);

    // R6: store miss to slot 7 (holds clean tag-1 line).
    rd0 = n_rd;
    wr0 = n_wr;
    do_store(mk(2, 7, 5), 32'hCAFE_0705);
    do_load(mk(2, 7, 5), got);
    chk("R6 merged word", got, 32'hCAFE_0705);
    do_load(mk(2, 7, 6), got);
    chk("R6 other word from memory", got, init_word(39, 6));
    chk("R6 hit after allocate", 32'(lat), 32'd1);
    chk("R6 one fill read", 32'(n_rd - rd0), 32'd1);
    chk("R6 no write", 32'(n_wr - wr0), 32'd0);
    do_load(mk(3, 7, 0), got);
    chk("R7 new line word", got, init_word(55, 0));
    chk("R6 allocated line dirty", 32'(n_wr - wr0), 32'd1);
    chk("R6 written word", bmem[39][5*32 +: 32], 32'hCAFE_0705);
    chk("R6 untouched word", bmem[39][6*32 +: 32], init_word(39, 6));

    chk("R9 stall during miss", 32'(stall_viol), 32'd0);
    chk("R10 request held", 32'(hold_viol), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule